// File: doc/BRIEF.md
# Framed Serial Register Port

This block is a synchronous serial slave that lets an external controller reach a peripheral's data register and status register over four wires: a serial clock, an active-high chip select, serial data in and serial data out. The serial clock is oversampled by the block's system clock. Its rising edges shift bits in and its falling edges move the output bit. Each frame has twelve bit slots. The controller first sends a start bit of 1. It then sends a direction bit (1 for read, 0 for write) and a register-select bit (0 for data, 1 for status). Eight data bits follow, most significant first. The frame ends with one handshake bit that the slave returns.

On the peripheral side, a data-register read pulls one byte from a receive queue, and a data-register write offers one byte to a transmit queue. Both interfaces use valid/ready. A byte moves only in a cycle where valid and ready are both high. The block raises `rx_ready` for exactly one cycle per data read. It raises `tx_valid` for exactly one cycle per data write and does not hold the offer. If `tx_ready` is low in that cycle, the byte is discarded and the handshake bit reports a full buffer. The block never waits on either queue, so back-pressure is reported to the controller and never stalls the serial link.

Top module: `serial_regport`

## Requirements
- R1: While `cs` is low the frame position is held at slot 0. With `cs` high, a rising serial clock edge in slot 0 that samples `sdi`=0 is ignored, and the frame starts only with the first sampled 1.
- R2: Slot 1 carries the direction (1 = read, 0 = write) and slot 2 the register select (0 = data register, 1 = status register).
- R3: `sdi` is sampled on rising serial clock edges, and `sdo` changes only after falling serial clock edges. Data bits occupy slots 3 to 10, bit 7 first, in both directions.
- R4: A data read with `rx_valid` high pops one byte (one `rx_ready` pulse, in the rising edge of slot 2), returns it, and ends with handshake bit 0.
- R5: A data read with `rx_valid` low pops nothing and returns the last byte popped (0x00 after reset) with handshake bit 1.
- R6: A data write offers the byte on `tx_data` with a one-cycle `tx_valid` at the rising edge of slot 10. If `tx_ready` is high the byte is taken and the handshake bit is 0.
- R7: A data write with `tx_ready` low transfers nothing, and the handshake bit is 1.
- R8: A status read returns {`stat_aux`[5:0], `tx_ready`, `rx_valid`}, with bit 0 as receive-data-available and bit 1 as transmit-space-available, all sampled at slot 2. It pops nothing and ends with handshake bit 0.
- R9: A status write transfers nothing and ends with handshake bit 0.
- R10: Dropping `cs` mid-frame aborts the frame without a transfer, forces `sdo` to 0, and the next frame runs normally.
- R11: After reset, `sdo`, `rx_ready` and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, idle low |
| cs | input | 1 | Active-high frame select |
| sdi | input | 1 | Serial data from controller |
| sdo | output | 1 | Serial data to controller |
| rx_valid | input | 1 | Receive queue holds a byte |
| rx_ready | output | 1 | One-cycle pop of the receive queue |
| rx_data | input | 8 | Head byte of the receive queue |
| tx_valid | output | 1 | One-cycle push offer to the transmit queue |
| tx_ready | input | 1 | Transmit queue has space |
| tx_data | output | 8 | Byte offered to the transmit queue |
| stat_aux | input | 6 | Upper six bits of the status byte |

## Verification
A rising serial clock edge is seen in the first system clock after `sclk` goes high. Pops and pushes are combinational pulses in that same cycle, so the bench's queue models count them at that edge and compare only after the frame has ended. A falling edge updates `sdo` one system clock after `sclk` goes low. The bench holds each serial half-period for two system clocks and reads `sdo` at the last falling system edge before it raises `sclk`, then reads it again at the end of the high phase to confirm it did not move. All comparisons use the full returned byte and handshake bit, computed from the stimulus and the queue model.

// File: rtl/serial_regport_pkg.sv
package serial_regport_pkg;
  typedef enum logic {DIR_WRITE = 1'b0, DIR_READ = 1'b1} dir_e;
  typedef enum logic {SEL_DATA = 1'b0, SEL_STATUS = 1'b1} sel_e;
endpackage

// File: rtl/srp_edge.sv
module srp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/srp_frame.sv
module srp_frame
  import serial_regport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int AUX_W  = DATA_W - 2,
  parameter int FRAME  = DATA_W + 4,
  parameter int CNT_W  = $clog2(FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sdi,
  input  logic              rise,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic [AUX_W-1:0]  stat_aux,
  output logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] obyte,
  output logic              flag
);
  localparam logic [CNT_W-1:0] SLOT_DIR   = CNT_W'(1);
  localparam logic [CNT_W-1:0] SLOT_SEL   = CNT_W'(2);
  localparam logic [CNT_W-1:0] SLOT_D0    = CNT_W'(3);
  localparam logic [CNT_W-1:0] SLOT_DLAST = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] SLOT_END   = CNT_W'(FRAME);

  dir_e              dir;
  sel_e              sel;
  logic [DATA_W-1:0] sreg;
  logic [DATA_W-1:0] last_rx;
  logic              active;

  assign active   = cs && rise && (cnt < SLOT_END);
  assign rx_ready = active && (cnt == SLOT_SEL) && (dir == DIR_READ) && !sdi;
  assign tx_valid = active && (cnt == SLOT_DLAST) && (dir == DIR_WRITE) && (sel == SEL_DATA);
  assign tx_data  = {sreg[DATA_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      dir     <= DIR_WRITE;
      sel     <= SEL_DATA;
      sreg    <= '0;
      last_rx <= '0;
      obyte   <= '0;
      flag    <= 1'b0;
    end else if (!cs) begin
      cnt <= '0;
    end else if (active) begin
      if (cnt != '0 || sdi) cnt <= cnt + CNT_W'(1);
      if (cnt == SLOT_DIR) dir <= dir_e'(sdi);
      if (cnt == SLOT_SEL) begin
        sel  <= sel_e'(sdi);
        flag <= 1'b0;
        if (dir == DIR_READ) begin
          if (sdi) begin
            obyte <= {stat_aux, tx_ready, rx_valid};
          end else if (rx_valid) begin
            obyte   <= rx_data;
            last_rx <= rx_data;
          end else begin
            obyte <= last_rx;
            flag  <= 1'b1;
          end
        end else begin
          obyte <= '0;
        end
      end
      if (cnt >= SLOT_D0 && cnt <= SLOT_DLAST) sreg <= {sreg[DATA_W-2:0], sdi};
      if (cnt == SLOT_DLAST && dir == DIR_WRITE)
        flag <= (sel == SEL_DATA) ? ~tx_ready : 1'b0;
    end
  end

  assert_cnt_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= SLOT_END);
  assert_cs_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (cnt == '0));
  assert_pop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !rx_ready);
  assert_push_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);
  assert_empty_stale_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rx_valid) |=> flag);
  assert_full_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> flag);
endmodule

// File: rtl/srp_sdo.sv
module srp_sdo #(
  parameter int DATA_W = 8,
  parameter int FRAME  = DATA_W + 4,
  parameter int CNT_W  = $clog2(FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              fall,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] obyte,
  input  logic              flag,
  output logic              sdo
);
  localparam logic [CNT_W-1:0] SLOT_FLAG = CNT_W'(DATA_W + 3);

  logic next_bit;

  always_comb begin
    next_bit = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (cnt == CNT_W'(DATA_W + 2 - i)) next_bit = obyte[i];
    if (cnt == SLOT_FLAG) next_bit = flag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !cs) sdo <= 1'b0;
    else if (fall)     sdo <= next_bit;
  end

  assert_sdo_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !sdo);
  assert_sdo_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && cs) |=> $stable(sdo));
endmodule

// File: rtl/serial_regport.sv
module serial_regport #(
  parameter int DATA_W = 8,
  parameter int AUX_W  = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs,
  input  logic              sdi,
  output logic              sdo,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic [AUX_W-1:0]  stat_aux
);
  localparam int FRAME = DATA_W + 4;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic              rise, fall, flag;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] obyte;

  srp_edge u_edge (.clk(clk), .rst_n(rst_n), .sclk(sclk), .rise(rise), .fall(fall));

  srp_frame #(.DATA_W(DATA_W), .AUX_W(AUX_W), .FRAME(FRAME), .CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sdi(sdi), .rise(rise),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .stat_aux(stat_aux), .cnt(cnt), .obyte(obyte), .flag(flag));

  srp_sdo #(.DATA_W(DATA_W), .FRAME(FRAME), .CNT_W(CNT_W)) u_sdo (
    .clk(clk), .rst_n(rst_n), .cs(cs), .fall(fall), .cnt(cnt),
    .obyte(obyte), .flag(flag), .sdo(sdo));

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |=> (!sdo && !rx_ready && !tx_valid));
endmodule

// File: tb/sim_serial_regport.sv
module sim_serial_regport;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs = 1'b0, sdi = 1'b0;
  logic       sdo;
  logic       rx_have = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_byte = 8'h00;
  logic       tx_valid;
  logic       tx_full = 1'b0;
  logic [7:0] tx_data;
  logic [5:0] aux = 6'h00;

  int vectors = 0, errors = 0, pops = 0, pushes = 0, r3_moves = 0;
  logic [7:0] got = 8'h00;

  always #2.5 clk = ~clk;

  serial_regport u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs(cs), .sdi(sdi), .sdo(sdo),
    .rx_valid(rx_have), .rx_ready(rx_ready), .rx_data(rx_byte),
    .tx_valid(tx_valid), .tx_ready(!tx_full), .tx_data(tx_data),
    .stat_aux(aux));

  always @(posedge clk) begin
    if (rx_ready && rx_have) pops <= pops + 1;
    if (tx_valid && !tx_full) begin
      pushes <= pushes + 1;
      got    <= tx_data;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic o);
    @(negedge clk);
    sdi  = b;
    sclk = 1'b0;
    repeat (HALF - 1) @(negedge clk);
    o    = sdo;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    if (sdo !== o) r3_moves++;
  endtask

  task automatic frame(input int pre, input logic rw, input logic sel, input logic [7:0] d,
                       output logic [7:0] q, output logic fl);
    logic o;
    @(negedge clk);
    cs = 1'b1;
    for (int i = 0; i < pre; i++) sbit(1'b0, o);
    sbit(1'b1, o);
    sbit(rw, o);
    sbit(sel, o);
    for (int i = 7; i >= 0; i--) begin
      sbit(d[i], o);
      q[i] = o;
    end
    sbit(1'b0, o);
    fl = o;
    @(negedge clk);
    sclk = 1'b0;
    cs   = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] q;
    logic fl, o;
    int p0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: quiet outputs after reset
    chk(sdo == 1'b0 && !rx_ready && !tx_valid, "R11", {sdo, rx_ready, tx_valid}, 0);

    // R5: empty read right after reset returns 0x00, stale
    frame(0, 1'b1, 1'b0, 8'h00, q, fl);
    chk(q == 8'h00 && fl == 1'b1, "R5", {q, fl}, {8'h00, 1'b1});
    chk(pops == 0, "R5", pops, 0);

    // R6 / R2 / R3: all byte values written and accepted
    for (int v = 0; v < 256; v++) begin
      p0 = pushes;
      frame(0, 1'b0, 1'b0, v[7:0], q, fl);
      chk(fl == 1'b0, "R6", fl, 0);
      chk(pushes == p0 + 1 && got == v[7:0], "R6", got, v);
    end

    // R7: writes into a full queue are dropped
    tx_full = 1'b1;
    for (int v = 0; v < 256; v += 51) begin
      p0 = pushes;
      frame(0, 1'b0, 1'b0, v[7:0], q, fl);
      chk(fl == 1'b1 && pushes == p0, "R7", {pushes - p0, fl}, 1);
    end
    tx_full = 1'b0;

    // R4 / R3: all byte values read back MSB first
    for (int v = 0; v < 256; v++) begin
      p0 = pops;
      rx_byte = v[7:0];
      rx_have = 1'b1;
      frame(0, 1'b1, 1'b0, 8'h00, q, fl);
      rx_have = 1'b0;
      chk(q == v[7:0] && fl == 1'b0, "R4", {q, fl}, {v[7:0], 1'b0});
      chk(pops == p0 + 1, "R4", pops - p0, 1);
    end

    // R5: empty queue returns last popped byte, stale
    rx_byte = 8'h3C;
    frame(0, 1'b1, 1'b0, 8'h00, q, fl);
    chk(q == 8'hFF && fl == 1'b1, "R5", {q, fl}, {8'hFF, 1'b1});

    // R8 / R2: status register read
    for (int k = 0; k < 16; k++) begin
      p0 = pops;
      rx_have = k[0];
      tx_full = k[1];
      aux = {k[3:2], 2'b01, k[1:0]};
      frame(0, 1'b1, 1'b1, 8'h00, q, fl);
      chk(q == {aux, ~tx_full, rx_have} && fl == 1'b0, "R8", q, {aux, ~tx_full, rx_have});
      chk(pops == p0, "R8", pops - p0, 0);
    end
    rx_have = 1'b0;
    tx_full = 1'b0;

    // R9: status register write has no effect
    p0 = pushes;
    frame(0, 1'b0, 1'b1, 8'hA5, q, fl);
    chk(fl == 1'b0 && pushes == p0, "R9", {pushes - p0, fl}, 0);

    // R1: leading zero bits before start are ignored
    p0 = pushes;
    frame(3, 1'b0, 1'b0, 8'h96, q, fl);
    chk(fl == 1'b0 && pushes == p0 + 1 && got == 8'h96, "R1", got, 8'h96);

    // R10: abort mid-frame
    p0 = pushes;
    @(negedge clk);
    cs = 1'b1;
    sbit(1'b1, o); sbit(1'b0, o); sbit(1'b0, o);
    for (int i = 0; i < 5; i++) sbit(1'b1, o);
    @(negedge clk);
    sclk = 1'b0;
    cs = 1'b0;
    repeat (3) @(negedge clk);
    chk(pushes == p0 && sdo == 1'b0, "R10", {pushes - p0, sdo}, 0);
    rx_byte = 8'h5A;
    rx_have = 1'b1;
    frame(0, 1'b1, 1'b0, 8'h00, q, fl);
    rx_have = 1'b0;
    chk(q == 8'h5A && fl == 1'b0, "R10", q, 8'h5A);

    // R3: sdo never moved during a high phase of sclk
    chk(r3_moves == 0, "R3", r3_moves, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule